// File: doc/BRIEF.md
# Integer Execute Stage with Immediate Operands

This block is the arithmetic and logic stage of a simple three-operand load/store processor pipeline. Each cycle it receives an already decoded operation code, the two source register values, the five-bit shift-count field and the sixteen-bit immediate field of the current instruction. It returns a 32-bit result and a signed-overflow flag, both registered, one clock after the inputs are sampled.

The stage widens the immediate field in one of three ways, depending on the operation. Arithmetic forms sign-extend it. Bitwise forms zero-extend it. The upper-load form places it in the high half of the word. A shift takes its count either from the instruction field or from the low bits of the first register operand. The overflow flag is only reported. Trapping and register write-back belong to the surrounding pipeline.

Top module: `ex_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result_o` becomes 0 and `ovf_o` becomes 0 after that edge.
- R2: Outputs are registered. The values after a rising edge are computed from `op_i`, `rs_val_i` (A), `rt_val_i` (B), `shamt_i` and `imm_i` as sampled at that edge. The opcodes are: 0 add, 1 sub, 2 and, 3 or, 4 nor, 5 xor, 6 set-less-than, 7 add-imm, 8 and-imm, 9 or-imm, 10 xor-imm, 11 set-less-than-imm, 12 upper-load, 13 shift-left, 14 shift-right-logical, 15 shift-right-arithmetic, 16 shift-left-variable, 17 shift-right-logical-variable, 18 shift-right-arithmetic-variable.
- R3: `ovf_o` is 1 exactly when add, add-imm or sub overflows as a signed 32-bit operation. An add overflows when both operands have the same sign and the result sign differs. A sub uses B inverted for this test. Every other opcode gives `ovf_o` = 0.
- R4: Add gives A+B, sub gives A−B, and add-imm gives A plus the immediate with bit 15 copied into bits 31:16. All are taken modulo 2^32.
- R5: And, or, xor and nor combine A and B bit by bit. Nor gives ~(A|B).
- R6: And-imm, or-imm and xor-imm combine A with the immediate, using zeros in bits 31:16 of the immediate.
- R7: Upper-load gives the immediate in bits 31:16 and zero in bits 15:0, and ignores A. An or-imm on that result then builds any 32-bit constant.
- R8: Set-less-than gives 1 if A < B as signed numbers, otherwise 0. Set-less-than-imm compares A against the sign-extended immediate. The answer is correct even when A−B overflows.
- R9: The constant shifts move B by `shamt_i`. The logical shifts fill vacated bits with 0. The arithmetic right shift fills vacated bits with B[31].
- R10: The variable shifts move B by A[4:0]. `shamt_i` and A[31:5] have no effect.
- R11: Opcodes 19 to 31 give `result_o` = 0 and `ovf_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Decoded operation code |
| rs_val_i | input | 32 | First source operand (A) |
| rt_val_i | input | 32 | Second source operand (B), also the shifted value |
| shamt_i | input | 5 | Constant shift count field |
| imm_i | input | 16 | Immediate field |
| result_o | output | 32 | Registered result |
| ovf_o | output | 1 | Registered signed-overflow flag |

## Verification
The assertions compare each output against the opcode and operands sampled one edge earlier. They therefore assume that every input is stable and known at each rising edge, and that the first edge after reset carries no meaning beyond the cleared outputs. The bench drives all inputs at the falling edge and holds them across the next rising edge. Before it checks any result it releases reset for good, except during the deliberate mid-run reset check.

// File: rtl/ex_pkg.sv
package ex_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 5'd0,
    OP_SUB   = 5'd1,
    OP_AND   = 5'd2,
    OP_OR    = 5'd3,
    OP_NOR   = 5'd4,
    OP_XOR   = 5'd5,
    OP_SLT   = 5'd6,
    OP_ADDI  = 5'd7,
    OP_ANDI  = 5'd8,
    OP_ORI   = 5'd9,
    OP_XORI  = 5'd10,
    OP_SLTI  = 5'd11,
    OP_LUI   = 5'd12,
    OP_SLL   = 5'd13,
    OP_SRL   = 5'd14,
    OP_SRA   = 5'd15,
    OP_SLLV  = 5'd16,
    OP_SRLV  = 5'd17,
    OP_SRAV  = 5'd18
  } op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_NOR = 2'd2,
    LG_XOR = 2'd3
  } lsel_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RLOG  = 2'd1,
    SH_RARI  = 2'd2
  } shk_e;
endpackage

// File: rtl/ex_immgen.sv
module ex_immgen
  import ex_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [OP_W-1:0]  op,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  imm_ext
);
  localparam int PAD = XLEN - IMM_W;

  always_comb begin
    unique case (op)
      OP_ADDI, OP_SLTI: imm_ext = {{PAD{imm[IMM_W-1]}}, imm};
      OP_LUI:           imm_ext = {imm, {PAD{1'b0}}};
      default:          imm_ext = {{PAD{1'b0}}, imm};
    endcase
  end
endmodule

// File: rtl/ex_addsub.sv
module ex_addsub #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            sub,
  output logic [XLEN-1:0] sum,
  output logic            ovf,
  output logic            lt
);
  logic [XLEN-1:0] bx;
  logic [XLEN:0]   wide;
  logic            c_top;

  assign bx    = b ^ {XLEN{sub}};
  assign wide  = {1'b0, a} + {1'b0, bx} + {{XLEN{1'b0}}, sub};
  assign sum   = wide[XLEN-1:0];
  // carry into the sign position versus carry out of it
  assign c_top = a[XLEN-1] ^ bx[XLEN-1] ^ wide[XLEN-1];
  assign ovf   = c_top ^ wide[XLEN];
  assign lt    = wide[XLEN-1] ^ ovf;
endmodule

// File: rtl/ex_logic.sv
module ex_logic
  import ex_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  lsel_e           sel,
  output logic [XLEN-1:0] y
);
  always_comb begin
    unique case (sel)
      LG_AND:  y = a & b;
      LG_OR:   y = a | b;
      LG_NOR:  y = ~(a | b);
      default: y = a ^ b;
    endcase
  end
endmodule

// File: rtl/ex_shift.sv
module ex_shift
  import ex_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int SHW  = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] val,
  input  logic [SHW-1:0]  cnt,
  input  shk_e            kind,
  output logic [XLEN-1:0] y
);
  logic            left;
  logic            fill;
  logic [XLEN-1:0] val_rev;
  logic [XLEN-1:0] core_out;
  logic [XLEN-1:0] out_rev;
  logic [XLEN-1:0] stg [0:SHW];

  assign left = (kind == SH_LEFT);
  assign fill = (kind == SH_RARI) & val[XLEN-1];

  // a left shift is a right shift on the bit-reversed word
  for (genvar i = 0; i < XLEN; i++) begin : g_rev
    assign val_rev[i] = val[XLEN-1-i];
    assign out_rev[i] = core_out[XLEN-1-i];
  end

  assign stg[0] = left ? val_rev : val;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int D = 1 << k;
    assign stg[k+1] = cnt[k] ? {{D{fill}}, stg[k][XLEN-1:D]} : stg[k];
  end

  assign core_out = stg[SHW];
  assign y        = left ? out_rev : core_out;
endmodule

// File: rtl/ex_unit.sv
module ex_unit
  import ex_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int SHW   = $clog2(XLEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  op_i,
  input  logic [XLEN-1:0]  rs_val_i,
  input  logic [XLEN-1:0]  rt_val_i,
  input  logic [SHW-1:0]   shamt_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [XLEN-1:0]  result_o,
  output logic             ovf_o
);
  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] opnd_b;
  logic            use_imm;
  logic            do_sub;
  logic [XLEN-1:0] as_sum;
  logic            as_ovf;
  logic            as_lt;
  lsel_e           lsel;
  logic [XLEN-1:0] lg_y;
  shk_e            shk;
  logic            sh_var;
  logic [SHW-1:0]  sh_cnt;
  logic [XLEN-1:0] sh_y;
  logic [XLEN-1:0] res_n;
  logic            ovf_n;

  ex_immgen #(.XLEN(XLEN), .IMM_W(IMM_W)) u_imm (
    .op      (op_i),
    .imm     (imm_i),
    .imm_ext (imm_ext)
  );

  always_comb begin
    use_imm = 1'b0;
    do_sub  = 1'b0;
    lsel    = LG_AND;
    shk     = SH_LEFT;
    sh_var  = 1'b0;
    unique case (op_i)
      OP_SUB, OP_SLT: do_sub = 1'b1;
      OP_SLTI:        begin do_sub = 1'b1; use_imm = 1'b1; end
      OP_ADDI, OP_LUI: use_imm = 1'b1;
      OP_OR:          lsel = LG_OR;
      OP_NOR:         lsel = LG_NOR;
      OP_XOR:         lsel = LG_XOR;
      OP_ANDI:        begin lsel = LG_AND; use_imm = 1'b1; end
      OP_ORI:         begin lsel = LG_OR;  use_imm = 1'b1; end
      OP_XORI:        begin lsel = LG_XOR; use_imm = 1'b1; end
      OP_SRL:         shk = SH_RLOG;
      OP_SRA:         shk = SH_RARI;
      OP_SLLV:        sh_var = 1'b1;
      OP_SRLV:        begin shk = SH_RLOG; sh_var = 1'b1; end
      OP_SRAV:        begin shk = SH_RARI; sh_var = 1'b1; end
      default:        ;
    endcase
  end

  assign opnd_b = use_imm ? imm_ext : rt_val_i;
  assign sh_cnt = sh_var ? rs_val_i[SHW-1:0] : shamt_i;

  ex_addsub #(.XLEN(XLEN)) u_as (
    .a   (rs_val_i),
    .b   (opnd_b),
    .sub (do_sub),
    .sum (as_sum),
    .ovf (as_ovf),
    .lt  (as_lt)
  );

  ex_logic #(.XLEN(XLEN)) u_lg (
    .a   (rs_val_i),
    .b   (opnd_b),
    .sel (lsel),
    .y   (lg_y)
  );

  ex_shift #(.XLEN(XLEN), .SHW(SHW)) u_sh (
    .val  (rt_val_i),
    .cnt  (sh_cnt),
    .kind (shk),
    .y    (sh_y)
  );

  always_comb begin
    res_n = '0;
    ovf_n = 1'b0;
    unique case (op_i)
      OP_ADD, OP_SUB, OP_ADDI: begin res_n = as_sum; ovf_n = as_ovf; end
      OP_SLT, OP_SLTI:         res_n = {{(XLEN-1){1'b0}}, as_lt};
      OP_AND, OP_OR, OP_NOR, OP_XOR,
      OP_ANDI, OP_ORI, OP_XORI: res_n = lg_y;
      OP_LUI:                  res_n = imm_ext;
      OP_SLL, OP_SRL, OP_SRA,
      OP_SLLV, OP_SRLV, OP_SRAV: res_n = sh_y;
      default:                 ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      ovf_o    <= 1'b0;
    end else begin
      result_o <= res_n;
      ovf_o    <= ovf_n;
    end
  end
endmodule

// File: rtl/ex_unit_chk.sv
module ex_unit_chk
  import ex_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int SHW   = $clog2(XLEN)
) (
  input logic             clk,
  input logic             rst,
  input logic [OP_W-1:0]  op_i,
  input logic [XLEN-1:0]  rs_val_i,
  input logic [XLEN-1:0]  rt_val_i,
  input logic [SHW-1:0]   shamt_i,
  input logic [IMM_W-1:0] imm_i,
  input logic [XLEN-1:0]  result_o,
  input logic             ovf_o
);
  localparam int PAD = XLEN - IMM_W;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (result_o == '0 && !ovf_o));

  assert_ovf_only_arith_R3: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> (!$past(rst) && ($past(op_i) == OP_ADD || $past(op_i) == OP_SUB
                               || $past(op_i) == OP_ADDI)));

  assert_zext_upper_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_ANDI) |-> (result_o[XLEN-1:IMM_W] == '0));

  assert_lui_low_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_LUI)
      |-> (result_o == {$past(imm_i), {PAD{1'b0}}}));

  assert_slt_bool_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) == OP_SLT || $past(op_i) == OP_SLTI))
      |-> (result_o[XLEN-1:1] == '0));

  assert_sra_sign_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_SRA)
      |-> (result_o[XLEN-1] == $past(rt_val_i[XLEN-1])));

  assert_unused_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) > OP_SRAV) |-> (result_o == '0 && !ovf_o));
endmodule

bind ex_unit ex_unit_chk #(.XLEN(XLEN), .IMM_W(IMM_W), .SHW(SHW)) u_chk (.*);

// File: tb/tb_ex_unit.sv
`timescale 1ns/1ps
module tb_ex_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  op_i = '0;
  logic [31:0] rs_val_i = '0;
  logic [31:0] rt_val_i = '0;
  logic [4:0]  shamt_i = '0;
  logic [15:0] imm_i = '0;
  logic [31:0] result_o;
  logic        ovf_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ex_unit dut (
    .clk      (clk),
    .rst      (rst),
    .op_i     (op_i),
    .rs_val_i (rs_val_i),
    .rt_val_i (rt_val_i),
    .shamt_i  (shamt_i),
    .imm_i    (imm_i),
    .result_o (result_o),
    .ovf_o    (ovf_o)
  );

  function automatic string tag(input int op);
    if (op == 0 || op == 1 || op == 7) return "R4";
    if (op >= 2 && op <= 5)            return "R5";
    if (op == 6 || op == 11)           return "R8";
    if (op >= 8 && op <= 10)           return "R6";
    if (op == 12)                      return "R7";
    if (op >= 13 && op <= 15)          return "R9";
    if (op >= 16 && op <= 18)          return "R10";
    return "R11";
  endfunction

  // behavioural model: {overflow, result}
  function automatic logic [32:0] model(input int op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [4:0] sh,
                                        input logic [15:0] im);
    logic [31:0] sx, zx, r;
    logic        v;
    longint      ws;
    sx = {{16{im[15]}}, im};
    zx = {16'h0, im};
    r  = '0;
    v  = 1'b0;
    case (op)
      0:  begin ws = longint'($signed(a)) + longint'($signed(b));
                r = a + b; v = (ws > 64'sd2147483647) || (ws < -64'sd2147483648); end
      1:  begin ws = longint'($signed(a)) - longint'($signed(b));
                r = a - b; v = (ws > 64'sd2147483647) || (ws < -64'sd2147483648); end
      7:  begin ws = longint'($signed(a)) + longint'($signed(sx));
                r = a + sx; v = (ws > 64'sd2147483647) || (ws < -64'sd2147483648); end
      2:  r = a & b;
      3:  r = a | b;
      4:  r = ~(a | b);
      5:  r = a ^ b;
      6:  r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      8:  r = a & zx;
      9:  r = a | zx;
      10: r = a ^ zx;
      11: r = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0;
      12: r = {im, 16'h0};
      13: r = b << sh;
      14: r = b >> sh;
      15: r = $unsigned($signed(b) >>> sh);
      16: r = b << a[4:0];
      17: r = b >> a[4:0];
      18: r = $unsigned($signed(b) >>> a[4:0]);
      default: r = '0;
    endcase
    return {v, r};
  endfunction

  // R2: inputs set at the falling edge, outputs read 1 ns after the next rising edge
  task automatic run(input int op, input logic [31:0] a, input logic [31:0] b,
                     input logic [4:0] sh, input logic [15:0] im);
    logic [32:0] e;
    @(negedge clk);
    op_i = op[4:0]; rs_val_i = a; rt_val_i = b; shamt_i = sh; imm_i = im;
    @(posedge clk);
    #1;
    e = model(op, a, b, sh, im);
    checks++;
    if (result_o !== e[31:0]) begin
      errors++;
      $display("FAIL %s (R2 timing) op=%0d a=%h b=%h sh=%0d imm=%h: result actual=%h expected=%h",
               tag(op), op, a, b, sh, im, result_o, e[31:0]);
    end
    checks++;
    if (ovf_o !== e[32]) begin
      errors++;
      $display("FAIL R3 op=%0d a=%h b=%h imm=%h: ovf actual=%b expected=%b",
               op, a, b, im, ovf_o, e[32]);
    end
  endtask

  initial begin
    #900000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] corner [6];
    logic [15:0] imms [4];
    logic [4:0]  shs [3];
    logic [31:0] hi_word;
    corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001;
    corner[2] = 32'h7FFF_FFFF; corner[3] = 32'h8000_0000;
    corner[4] = 32'hFFFF_FFFF; corner[5] = 32'hA5C3_3C5A;
    imms[0] = 16'h0000; imms[1] = 16'h7FFF; imms[2] = 16'h8000; imms[3] = 16'hFFFF;
    shs[0] = 5'd0; shs[1] = 5'd1; shs[2] = 5'd31;

    // R1: reset state
    repeat (2) @(posedge clk);
    #1;
    checks++;
    if (result_o !== 32'h0 || ovf_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: actual=%h/%b expected=00000000/0", result_o, ovf_o);
    end
    @(negedge clk);
    rst = 1'b0;

    // near-exhaustive sweep over opcodes, corner operands, immediates and counts
    for (int op = 0; op < 32; op++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          for (int k = 0; k < 4; k++)
            for (int s = 0; s < 3; s++)
              run(op, corner[i], corner[j], shs[s], imms[k]);

    // R10: variable counts with upper bits of A set and shamt disagreeing
    for (int c = 0; c < 32; c++)
      for (int op = 16; op < 19; op++)
        run(op, 32'hFFFF_FFE0 | c, 32'h8765_4321, 5'(31 - c), 16'h1234);

    // random operands across all defined opcodes
    for (int n = 0; n < 3000; n++)
      run(n % 19, $urandom, $urandom, 5'($urandom), 16'($urandom));

    // R7: upper-load followed by or-imm builds a full constant
    run(12, 32'hDEAD_BEEF, 32'h0, 5'd0, 16'hAA55);
    hi_word = result_o;
    run(9, hi_word, 32'h0, 5'd0, 16'hCC33);
    checks++;
    if (result_o !== 32'hAA55_CC33) begin
      errors++;
      $display("FAIL R7 constant build: actual=%h expected=aa55cc33", result_o);
    end

    // R1: reset mid-run overrides an overflowing add
    @(negedge clk);
    op_i = 5'd0; rs_val_i = 32'h7FFF_FFFF; rt_val_i = 32'h1; rst = 1'b1;
    @(posedge clk);
    #1;
    checks++;
    if (result_o !== 32'h0 || ovf_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 mid-run reset: actual=%h/%b expected=00000000/0", result_o, ovf_o);
    end
    @(negedge clk);
    rst = 1'b0;
    run(0, 32'h7FFF_FFFF, 32'h1, 5'd0, 16'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule